// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block keeps the pointer state for two independent receive descriptor rings that live in host memory. Software sets up each ring through a small register port: a 64-bit base address, a ring size in bytes, a head offset, a tail offset and a mode bit. The slots between head and tail belong to hardware. Every other slot belongs to software.

The receive datapath asks the block for the next free descriptor slot. If the ring has work for it, the block grants the request in the same cycle and supplies the host address of that slot. When descriptors have been written back, the datapath reports how many. Head then moves forward by that many descriptors. A write-back that claims more descriptors than have been fetched sets a sticky error flag.

In split mode each descriptor is 32 bytes, so every fetch and every written-back descriptor covers two 16-byte slots. The block also reports, for each ring, how many slots hardware owns and whether the ring is empty.

Top module: `rxq_ring_tracker`

## Requirements
- R1: The ring base is 64 bits, written as a low word (register 0) and a high word (register 1). Bits 3:0 of the low word are ignored and read back as zero. A granted fetch returns the address base + 16 × fetch pointer.
- R2: The size register (register 2) keeps only bits 20:7 of the written byte count and reads back that masked value. The ring holds size/16 slots. A ring of size zero refuses every fetch.
- R3: The owned count is (tail − head) modulo the slot count. It reads back in bits 15:0 of the status register (register 6) and on `owned_cnt`. `ring_empty` is high exactly when the owned count is zero.
- R4: A fetch is granted only when it is requested and at least one descriptor step of slots lies between the fetch pointer and tail. Each grant moves the fetch pointer forward by one step, wrapping to zero at the slot count.
- R5: A valid write-back of N descriptors moves head forward by N steps, modulo the slot count.
- R6: A write-back larger than the slots fetched but not yet written back leaves head unchanged. It sets a sticky error flag, seen on `ring_err` and in status bit 16.
- R7: Control register 5, bit 0, selects split mode. In split mode one step is two slots; otherwise a step is one slot.
- R8: Writing the base or size registers of a ring zeroes its head and fetch pointer and clears its error flag.
- R9: Writing head (register 3) sets the fetch pointer to the same value. Writing tail (register 4) changes only tail.
- R10: Register address bit 3 picks the ring, and `fetch_ring` and `wb_ring` pick the ring for the datapath. Activity on one ring leaves the other ring's state unchanged.
- R11: After reset, every register of both rings reads zero, both rings are empty and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Ring select (bit 3) and register select (bits 2:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fetch_req | input | 1 | Datapath asks for a free descriptor slot |
| fetch_ring | input | 1 | Ring targeted by the fetch |
| fetch_grant | output | 1 | Fetch accepted this cycle |
| fetch_addr | output | 64 | Host address of the granted slot |
| wb_valid | input | 1 | Write-back completion strobe |
| wb_ring | input | 1 | Ring targeted by the write-back |
| wb_count | input | 4 | Descriptors written back |
| owned_cnt | output | 32 | Hardware-owned slot count, 16 bits per ring, ring 0 in the low half |
| ring_empty | output | 2 | Per-ring empty flag |
| ring_err | output | 2 | Per-ring sticky over-count flag |

## Verification
A wrong fetch pointer shows up on the next grant, either as a wrong `fetch_addr` or as a grant given or refused at the wrong time. A wrong head shows up at once on `owned_cnt` and `ring_empty`, and later as an error raised or not raised on the following write-back. A missed pointer clear after reconfiguration is visible on the next cycle in the head read-back and the status word. Wrap faults appear only on the fetch or write-back that crosses the slot count, so the stimulus deliberately places head near the end of the ring.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  parameter int unsigned PTR_W      = 16;
  parameter int unsigned SLOT_W     = PTR_W + 1;
  parameter int unsigned ADDR_W     = 64;
  parameter int unsigned DATA_W     = 32;
  parameter int unsigned DESC_SHIFT = 4;
  parameter int unsigned LEN_LO     = 7;
  parameter int unsigned LEN_HI     = 20;

  typedef enum logic [2:0] {
    CSR_BASE_LO = 3'd0,
    CSR_BASE_HI = 3'd1,
    CSR_SIZE    = 3'd2,
    CSR_HEAD    = 3'd3,
    CSR_TAIL    = 3'd4,
    CSR_CTRL    = 3'd5,
    CSR_STAT    = 3'd6,
    CSR_NONE    = 3'd7
  } csr_sel_e;

  // slots from 'from' up to (not including) 'to' on a ring of n slots
  function automatic logic [SLOT_W-1:0] ring_dist(
      input logic [PTR_W-1:0] from, input logic [PTR_W-1:0] to,
      input logic [SLOT_W-1:0] n);
    logic [SLOT_W:0] t;
    if (n == '0) t = '0;
    else if (to >= from) t = {2'b00, to} - {2'b00, from};
    else t = {2'b00, to} + {1'b0, n} - {2'b00, from};
    return t[SLOT_W-1:0];
  endfunction

  // pointer moved forward by amt slots, wrapping at n
  function automatic logic [PTR_W-1:0] ring_adv(
      input logic [PTR_W-1:0] p, input logic [SLOT_W-1:0] amt,
      input logic [SLOT_W-1:0] n);
    logic [SLOT_W:0] s;
    s = {2'b00, p} + {1'b0, amt};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[PTR_W-1:0];
  endfunction

  // slot count from the kept size field (bytes / 16)
  function automatic logic [SLOT_W-1:0] slot_total(input logic [LEN_HI:LEN_LO] f);
    return SLOT_W'({f, 3'b000});
  endfunction
endpackage

// File: rtl/rxr_ring_ctx.sv
module rxr_ring_ctx
  import rxr_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  csr_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fetch_req,
  input  logic              wb_valid,
  input  logic [CNT_W-1:0]  wb_cnt,
  output logic [ADDR_W-1:0] base_o,
  output logic [DATA_W-1:0] size_o,
  output logic [PTR_W-1:0]  head_o,
  output logic [PTR_W-1:0]  tail_o,
  output logic [PTR_W-1:0]  fptr_o,
  output logic              split_o,
  output logic              err_o,
  output logic [PTR_W-1:0]  owned_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              evt_fetch_o,
  output logic              evt_wb_ok_o,
  output logic              evt_wb_bad_o,
  output logic              cfg_clr_o
);
  logic [DATA_W-1:DESC_SHIFT] base_lo_q;
  logic [DATA_W-1:0]          base_hi_q;
  logic [LEN_HI:LEN_LO]       size_q;
  logic [PTR_W-1:0]           head_q, tail_q, fptr_q;
  logic                       split_q, err_q;

  logic [SLOT_W-1:0] slots, step, owned, avail, outst, wb_amt;
  logic              can_fetch, idle_port;

  assign slots     = slot_total(size_q);
  assign step      = split_q ? SLOT_W'(2) : SLOT_W'(1);
  assign owned     = ring_dist(head_q, tail_q, slots);
  assign avail     = ring_dist(fptr_q, tail_q, slots);
  assign outst     = ring_dist(head_q, fptr_q, slots);
  assign wb_amt    = split_q ? SLOT_W'({wb_cnt, 1'b0}) : SLOT_W'(wb_cnt);
  assign idle_port = !wr_hit;
  assign can_fetch = (slots != '0) && (avail >= step);

  assign evt_fetch_o  = fetch_req && can_fetch && idle_port;
  assign evt_wb_ok_o  = wb_valid && idle_port && (wb_amt <= outst);
  assign evt_wb_bad_o = wb_valid && idle_port && (wb_amt > outst);
  assign cfg_clr_o    = wr_hit && (wr_sel == CSR_BASE_LO || wr_sel == CSR_BASE_HI ||
                                   wr_sel == CSR_SIZE);

  assign base_o  = {base_hi_q, base_lo_q, {DESC_SHIFT{1'b0}}};
  assign size_o  = DATA_W'({size_q, {LEN_LO{1'b0}}});
  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign fptr_o  = fptr_q;
  assign split_o = split_q;
  assign err_o   = err_q;
  assign owned_o = owned[PTR_W-1:0];
  assign empty_o = (owned == '0);
  assign addr_o  = base_o + ADDR_W'({fptr_q, {DESC_SHIFT{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      size_q    <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      fptr_q    <= '0;
      split_q   <= 1'b0;
      err_q     <= 1'b0;
    end else if (wr_hit) begin
      if (cfg_clr_o) begin
        head_q <= '0;
        fptr_q <= '0;
        err_q  <= 1'b0;
      end
      case (wr_sel)
        CSR_BASE_LO: base_lo_q <= wdata[DATA_W-1:DESC_SHIFT];
        CSR_BASE_HI: base_hi_q <= wdata;
        CSR_SIZE:    size_q    <= wdata[LEN_HI:LEN_LO];
        CSR_HEAD: begin
          head_q <= wdata[PTR_W-1:0];
          fptr_q <= wdata[PTR_W-1:0];
        end
        CSR_TAIL:    tail_q  <= wdata[PTR_W-1:0];
        CSR_CTRL:    split_q <= wdata[0];
        default: ;
      endcase
    end else begin
      if (evt_fetch_o)  fptr_q <= ring_adv(fptr_q, step, slots);
      if (evt_wb_ok_o)  head_q <= ring_adv(head_q, wb_amt, slots);
      if (evt_wb_bad_o) err_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/rxr_csr.sv
module rxr_csr
  import rxr_pkg::*;
#(
  parameter int unsigned NRINGS = 2,
  parameter int unsigned RING_W = $clog2(NRINGS),
  parameter int unsigned RADR_W = RING_W + 3
) (
  input  logic                           reg_wr,
  input  logic [RADR_W-1:0]              reg_addr,
  input  logic [NRINGS-1:0][ADDR_W-1:0]  base_v,
  input  logic [NRINGS-1:0][DATA_W-1:0]  size_v,
  input  logic [NRINGS-1:0][PTR_W-1:0]   head_v,
  input  logic [NRINGS-1:0][PTR_W-1:0]   tail_v,
  input  logic [NRINGS-1:0][PTR_W-1:0]   owned_v,
  input  logic [NRINGS-1:0]              split_v,
  input  logic [NRINGS-1:0]              err_v,
  output logic [NRINGS-1:0]              wr_hit,
  output csr_sel_e                       wr_sel,
  output logic [DATA_W-1:0]              reg_rdata
);
  logic [RING_W-1:0] ring_idx;
  logic              idx_ok;

  assign ring_idx = reg_addr[RADR_W-1:3];
  assign wr_sel   = csr_sel_e'(reg_addr[2:0]);
  assign idx_ok   = (32'(ring_idx) < NRINGS);

  for (genvar g = 0; g < NRINGS; g++) begin : g_hit
    assign wr_hit[g] = reg_wr && (ring_idx == RING_W'(g));
  end

  always_comb begin
    reg_rdata = '0;
    if (idx_ok) begin
      case (wr_sel)
        CSR_BASE_LO: reg_rdata = base_v[ring_idx][DATA_W-1:0];
        CSR_BASE_HI: reg_rdata = base_v[ring_idx][ADDR_W-1:DATA_W];
        CSR_SIZE:    reg_rdata = size_v[ring_idx];
        CSR_HEAD:    reg_rdata = DATA_W'(head_v[ring_idx]);
        CSR_TAIL:    reg_rdata = DATA_W'(tail_v[ring_idx]);
        CSR_CTRL:    reg_rdata = DATA_W'(split_v[ring_idx]);
        CSR_STAT:    reg_rdata = DATA_W'({err_v[ring_idx], owned_v[ring_idx]});
        default:     reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxq_ring_tracker.sv
module rxq_ring_tracker
  import rxr_pkg::*;
#(
  parameter int unsigned NRINGS = 2,
  parameter int unsigned CNT_W  = 4,
  localparam int unsigned RING_W = $clog2(NRINGS),
  localparam int unsigned RADR_W = RING_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [RADR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    fetch_req,
  input  logic [RING_W-1:0]       fetch_ring,
  output logic                    fetch_grant,
  output logic [ADDR_W-1:0]       fetch_addr,
  input  logic                    wb_valid,
  input  logic [RING_W-1:0]       wb_ring,
  input  logic [CNT_W-1:0]        wb_count,
  output logic [NRINGS*PTR_W-1:0] owned_cnt,
  output logic [NRINGS-1:0]       ring_empty,
  output logic [NRINGS-1:0]       ring_err
);
  logic [NRINGS-1:0][ADDR_W-1:0] base_v, addr_v;
  logic [NRINGS-1:0][DATA_W-1:0] size_v;
  logic [NRINGS-1:0][PTR_W-1:0]  head_v, tail_v, fptr_v, owned_v;
  logic [NRINGS-1:0]             split_v, wr_hit;
  logic [NRINGS-1:0]             evt_fetch, evt_wb_ok, evt_wb_bad, cfg_clr;
  csr_sel_e                      wr_sel;

  rxr_csr #(.NRINGS(NRINGS)) u_csr (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .base_v   (base_v),
    .size_v   (size_v),
    .head_v   (head_v),
    .tail_v   (tail_v),
    .owned_v  (owned_v),
    .split_v  (split_v),
    .err_v    (ring_err),
    .wr_hit   (wr_hit),
    .wr_sel   (wr_sel),
    .reg_rdata(reg_rdata)
  );

  for (genvar g = 0; g < NRINGS; g++) begin : g_ring
    logic sel_fetch, sel_wb;
    assign sel_fetch = fetch_req && (fetch_ring == RING_W'(g));
    assign sel_wb    = wb_valid && (wb_ring == RING_W'(g));

    rxr_ring_ctx #(.CNT_W(CNT_W)) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit[g]),
      .wr_sel      (wr_sel),
      .wdata       (reg_wdata),
      .fetch_req   (sel_fetch),
      .wb_valid    (sel_wb),
      .wb_cnt      (wb_count),
      .base_o      (base_v[g]),
      .size_o      (size_v[g]),
      .head_o      (head_v[g]),
      .tail_o      (tail_v[g]),
      .fptr_o      (fptr_v[g]),
      .split_o     (split_v[g]),
      .err_o       (ring_err[g]),
      .owned_o     (owned_v[g]),
      .empty_o     (ring_empty[g]),
      .addr_o      (addr_v[g]),
      .evt_fetch_o (evt_fetch[g]),
      .evt_wb_ok_o (evt_wb_ok[g]),
      .evt_wb_bad_o(evt_wb_bad[g]),
      .cfg_clr_o   (cfg_clr[g])
    );
    assign owned_cnt[g*PTR_W +: PTR_W] = owned_v[g];
  end

  assign fetch_grant = |evt_fetch;
  assign fetch_addr  = addr_v[fetch_ring];
endmodule

// File: rtl/rxq_ring_tracker_chk.sv
module rxq_ring_tracker_chk
  import rxr_pkg::*;
#(
  parameter int unsigned NRINGS = 2,
  parameter int unsigned RING_W = $clog2(NRINGS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          fetch_req,
  input logic [RING_W-1:0]             fetch_ring,
  input logic                          fetch_grant,
  input logic [NRINGS-1:0]             ring_empty,
  input logic [NRINGS-1:0]             ring_err,
  input logic [NRINGS-1:0][PTR_W-1:0]  head_v,
  input logic [NRINGS-1:0][PTR_W-1:0]  fptr_v,
  input logic [NRINGS-1:0]             evt_fetch,
  input logic [NRINGS-1:0]             evt_wb_bad,
  input logic [NRINGS-1:0]             cfg_clr
);
  assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_grant |-> fetch_req);

  assert_grant_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_grant |-> !ring_empty[fetch_ring]);

  for (genvar g = 0; g < NRINGS; g++) begin : g_chk
    assert_fetch_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fetch[g] |=> !$stable(fptr_v[g]));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_err[g] && !cfg_clr[g]) |=> ring_err[g]);

    assert_bad_wb_holds_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_wb_bad[g] |=> ($stable(head_v[g]) && ring_err[g]));

    assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clr[g] |=> (head_v[g] == '0 && fptr_v[g] == '0 && !ring_err[g]));
  end
endmodule

bind rxq_ring_tracker rxq_ring_tracker_chk #(.NRINGS(NRINGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_req  (fetch_req),
  .fetch_ring (fetch_ring),
  .fetch_grant(fetch_grant),
  .ring_empty (ring_empty),
  .ring_err   (ring_err),
  .head_v     (head_v),
  .fptr_v     (fptr_v),
  .evt_fetch  (evt_fetch),
  .evt_wb_bad (evt_wb_bad),
  .cfg_clr    (cfg_clr)
);

// File: tb/rxq_ring_tracker_bench.sv
`timescale 1ns/1ps
module rxq_ring_tracker_bench;
  localparam int NR = 2;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_req = 1'b0;
  logic        fetch_ring = 1'b0;
  logic        fetch_grant;
  logic [63:0] fetch_addr;
  logic        wb_valid = 1'b0;
  logic        wb_ring = 1'b0;
  logic [CW-1:0] wb_count = '0;
  logic [31:0] owned_cnt;
  logic [1:0]  ring_empty, ring_err;

  rxq_ring_tracker #(.NRINGS(NR), .CNT_W(CW)) u_rxq_ring_tracker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_ring(fetch_ring), .fetch_grant(fetch_grant), .fetch_addr(fetch_addr),
    .wb_valid(wb_valid), .wb_ring(wb_ring), .wb_count(wb_count),
    .owned_cnt(owned_cnt), .ring_empty(ring_empty), .ring_err(ring_err)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reference model of both rings
  logic [63:0] m_base[NR];
  int m_slots[NR], m_head[NR], m_tail[NR], m_fptr[NR];
  logic [31:0] m_size[NR];
  bit m_split[NR], m_err[NR];

  function automatic int mdist(int a, int b, int n);
    if (n == 0) return 0;
    return ((b - a) % n + n) % n;
  endfunction

  // scoreboard of expected fetch responses
  typedef struct { bit ok; logic [63:0] addr; string tag; } exp_t;
  exp_t sbq[$];
  event mon_ev;

  initial forever begin
    exp_t it;
    @(mon_ev);
    if (sbq.size() == 0) begin
      check(1'b0, "R4", "scoreboard underflow", 0, 1);
    end else begin
      it = sbq.pop_front();
      check(fetch_grant == it.ok, it.tag, "fetch grant", fetch_grant, it.ok);
      if (it.ok) check(fetch_addr == it.addr, it.tag, "fetch addr", fetch_addr, it.addr);
    end
  end

  task automatic wr(input int r, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(r * 8 + sel); reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
    case (sel)
      0: m_base[r][31:0]  = {d[31:4], 4'h0};
      1: m_base[r][63:32] = d;
      2: begin m_size[r] = d & 32'h001F_FF80; m_slots[r] = int'(m_size[r]) / 16; end
      3: begin m_head[r] = int'(d[15:0]); m_fptr[r] = int'(d[15:0]); end
      4: m_tail[r] = int'(d[15:0]);
      5: m_split[r] = d[0];
      default: ;
    endcase
    if (sel <= 2) begin m_head[r] = 0; m_fptr[r] = 0; m_err[r] = 1'b0; end
  endtask

  task automatic rd(input int r, input int sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = 4'(r * 8 + sel);
    #1 check(reg_rdata == exp, req, $sformatf("ring%0d reg%0d", r, sel), reg_rdata, exp);
  endtask

  task automatic stat(input int r, input string req);
    int own;
    own = mdist(m_head[r], m_tail[r], m_slots[r]);
    rd(r, 6, (32'(m_err[r]) << 16) | 32'(own), req);
    check(owned_cnt[r*16 +: 16] == 16'(own), req, "owned_cnt", owned_cnt[r*16 +: 16], own);
    check(ring_empty[r] == (own == 0), req, "ring_empty", ring_empty[r], own == 0);
    check(ring_err[r] == m_err[r], req, "ring_err", ring_err[r], m_err[r]);
  endtask

  task automatic fetch(input int r, input string req);
    exp_t it;
    int step;
    step = m_split[r] ? 2 : 1;
    @(negedge clk);
    fetch_req = 1'b1; fetch_ring = r[0];
    #1;
    it.ok = (m_slots[r] != 0) && (mdist(m_fptr[r], m_tail[r], m_slots[r]) >= step);
    it.addr = m_base[r] + 64'(m_fptr[r]) * 64'd16;
    it.tag = req;
    sbq.push_back(it);
    -> mon_ev;
    @(posedge clk); #1 fetch_req = 1'b0;
    if (it.ok) m_fptr[r] = (m_fptr[r] + step) % m_slots[r];
  endtask

  task automatic wb(input int r, input int cnt);
    int amt;
    amt = cnt * (m_split[r] ? 2 : 1);
    @(negedge clk);
    wb_valid = 1'b1; wb_ring = r[0]; wb_count = CW'(cnt);
    @(posedge clk); #1 wb_valid = 1'b0;
    if (amt > mdist(m_head[r], m_fptr[r], m_slots[r])) m_err[r] = 1'b1;
    else m_head[r] = (m_head[r] + amt) % m_slots[r];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_base[r] = '0; m_size[r] = '0; m_slots[r] = 0; m_head[r] = 0;
      m_tail[r] = 0; m_fptr[r] = 0; m_split[r] = 1'b0; m_err[r] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: reset state of every register
    for (int r = 0; r < NR; r++) begin
      for (int s = 0; s < 6; s++) rd(r, s, 32'h0, "R11");
      stat(r, "R11");
    end

    // R1, R2: base and size programming on ring 0
    wr(0, 0, 32'h1234_567F); rd(0, 0, 32'h1234_5670, "R1");
    wr(0, 1, 32'h0000_00AB); rd(0, 1, 32'h0000_00AB, "R1");
    wr(0, 2, 32'h0020_040F); rd(0, 2, 32'h0000_0400, "R2");

    // R3, R4: empty ring refuses, then five slots handed out
    fetch(0, "R3");
    wr(0, 4, 32'd5); stat(0, "R3");
    for (int k = 0; k < 5; k++) fetch(0, "R1");
    fetch(0, "R4");

    // R5, R6: write-backs, including an over-count
    wb(0, 3); stat(0, "R5");
    wb(0, 3); stat(0, "R6");
    wb(0, 2); stat(0, "R6");

    // R9 and wrap: head near the end of a 64-slot ring
    wr(0, 3, 32'd60); rd(0, 3, 32'd60, "R9");
    wr(0, 4, 32'd2); stat(0, "R3");
    fetch(0, "R9");
    for (int k = 0; k < 5; k++) fetch(0, "R4");
    fetch(0, "R4");
    wb(0, 6); stat(0, "R5");

    // R10, R7: ring 1 in split mode, ring 0 untouched
    wr(1, 0, 32'h8000_0000); wr(1, 1, 32'h0); wr(1, 2, 32'h800);
    wr(1, 5, 32'h1); rd(1, 5, 32'h1, "R7");
    wr(1, 4, 32'd8);
    stat(0, "R10"); rd(0, 0, 32'h1234_5670, "R10"); rd(0, 4, 32'd2, "R10");
    for (int k = 0; k < 4; k++) fetch(1, "R7");
    fetch(1, "R7");
    wb(1, 2); stat(1, "R7");
    wb(1, 3); stat(1, "R6");
    stat(0, "R10");
    wr(1, 4, 32'd9); fetch(1, "R7");

    // R8, R2: size zero clears pointers and error, refuses fetch
    wr(1, 2, 32'h0); stat(1, "R8"); rd(1, 3, 32'h0, "R8");
    fetch(1, "R2");

    // R8: base write on ring 0 clears its error and head
    wr(0, 0, 32'h0000_1000); rd(0, 3, 32'h0, "R8"); stat(0, "R8");
    wr(0, 4, 32'd3); fetch(0, "R8");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule